// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells the front end of an out-of-order core which in-flight store a newly fetched memory instruction should be ordered behind. It learns from ordering violations. When a load ran ahead of a store it depended on, the execution side reports the pair of program counters. The block then puts both instructions in a common store set.

Two tables hold what it has learned. The membership table maps each load or store PC to a set number. The recent-store table maps each set number to the tag of the youngest store of that set that has been fetched and has not yet completed. For every fetched instruction the block answers one cycle later with a valid flag, a dependence flag and the tag to wait for. A fetched store also becomes the youngest store of its own set. A clear pulse starts a walk that erases the membership table one entry per cycle.

The walker is a two-state machine. In state SCRUB_IDLE the tables are used normally, and the transition on a clear pulse goes to SCRUB_WALK. In SCRUB_WALK one membership entry is erased each cycle. After the last index the machine returns to SCRUB_IDLE, and further clear pulses during the walk are ignored.

Top module: `store_set_predictor`

## Requirements
- R1: After reset, pred_valid and pred_dep are low and no PC belongs to any set, so the first fetched instruction is predicted free of dependence.
- R2: A fetch presented in cycle n produces its answer on pred_valid/pred_dep/pred_tag after the edge ending cycle n, and pred_valid is high exactly in cycles that follow a fetch.
- R3: A fetched instruction whose PC has no set number gets pred_dep low and does not change the recent-store table.
- R4: A violation where neither PC has a set number gives both the set number equal to load PC bits [8:2]. The membership table is indexed by PC bits [11:2].
- R5: A fetched load with a set number reports pred_dep high with the tag held for that set, if that set has an in-flight store recorded.
- R6: A fetched store with a set number reports the previously recorded store of its set, if any. Its own tag then replaces that record.
- R7: A completion (PC and tag) invalidates the record of the completing store's set only if the record still holds that tag.
- R8: A violation where only one PC has a set number puts the other PC into that set.
- R9: A violation where both PCs have different set numbers writes the smaller of the two numbers to both PCs.
- R10: A clear pulse in SCRUB_IDLE moves to SCRUB_WALK for exactly 1024 cycles, erasing every membership entry. During the walk, fetches are answered with no dependence and violations are ignored. The recent-store table is left untouched.
- R11: A fetch reads both tables as they were before the edge, so a violation or completion in the same cycle does not affect that fetch's answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A memory instruction is fetched this cycle |
| fetch_pc | input | 32 | PC of the fetched instruction |
| fetch_is_store | input | 1 | 1 for store, 0 for load |
| fetch_tag | input | 6 | In-flight tag of the fetched instruction |
| done_valid | input | 1 | A store completes this cycle |
| done_pc | input | 32 | PC of the completing store |
| done_tag | input | 6 | Tag of the completing store |
| viol_valid | input | 1 | An ordering violation is reported |
| viol_load_pc | input | 32 | PC of the load that ran too early |
| viol_store_pc | input | 32 | PC of the store it conflicted with |
| clear_req | input | 1 | Pulse requesting a membership-table wipe |
| pred_valid | output | 1 | Answer for the previous cycle's fetch is present |
| pred_dep | output | 1 | The fetched instruction must wait |
| pred_tag | output | 6 | Tag to wait for (zero when pred_dep is low) |

## Verification
The checker assumes that clear_req is a pulse. It also assumes that fetches arrive on any cycle, including during a wipe, and that its walk-length count starts from a reset with the walker idle. The stimulus issues one clear pulse and places fetches and a violation inside the walk. It keeps completion tags equal to tags previously issued for the same PC. It uses PCs whose indices and derived set numbers are chosen not to collide unless a collision is the point of the check.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [0:0] {
        SCRUB_IDLE = 1'b0,
        SCRUB_WALK = 1'b1
    } scrub_state_e;

endpackage

// File: rtl/ssp_sid_table.sv
module ssp_sid_table #(
    parameter int IDX_W = 10,
    parameter int SID_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_a_idx,
    output logic             look_a_hit,
    output logic [SID_W-1:0] look_a_sid,
    input  logic [IDX_W-1:0] look_b_idx,
    output logic             look_b_hit,
    output logic [SID_W-1:0] look_b_sid,
    input  logic             train_en,
    input  logic [IDX_W-1:0] train_ld_idx,
    input  logic [IDX_W-1:0] train_st_idx,
    input  logic             wipe_en,
    input  logic [IDX_W-1:0] wipe_idx
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [SID_W-1:0] sid_mem [DEPTH];

    logic             ld_hit, st_hit;
    logic [SID_W-1:0] ld_sid, st_sid, merged_sid;

    assign look_a_hit = vld_q[look_a_idx];
    assign look_a_sid = sid_mem[look_a_idx];
    assign look_b_hit = vld_q[look_b_idx];
    assign look_b_sid = sid_mem[look_b_idx];

    assign ld_hit = vld_q[train_ld_idx];
    assign ld_sid = sid_mem[train_ld_idx];
    assign st_hit = vld_q[train_st_idx];
    assign st_sid = sid_mem[train_st_idx];

    always_comb begin
        unique case ({ld_hit, st_hit})
            2'b00:   merged_sid = train_ld_idx[SID_W-1:0];
            2'b10:   merged_sid = ld_sid;
            2'b01:   merged_sid = st_sid;
            default: merged_sid = (ld_sid < st_sid) ? ld_sid : st_sid;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wipe_en) begin
            vld_q[wipe_idx] <= 1'b0;
        end else if (train_en) begin
            vld_q[train_ld_idx] <= 1'b1;
            vld_q[train_st_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (train_en && !wipe_en) begin
            sid_mem[train_ld_idx] <= merged_sid;
            sid_mem[train_st_idx] <= merged_sid;
        end
    end

endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst #(
    parameter int SID_W = 7,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SID_W-1:0] rd_sid,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             set_en,
    input  logic [SID_W-1:0] set_sid,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             kill_en,
    input  logic [SID_W-1:0] kill_sid,
    input  logic [TAG_W-1:0] kill_tag
);
    localparam int DEPTH = 1 << SID_W;

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic             kill_match;

    assign rd_vld     = vld_q[rd_sid];
    assign rd_tag     = tag_mem[rd_sid];
    assign kill_match = kill_en && vld_q[kill_sid] && (tag_mem[kill_sid] == kill_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (kill_match) vld_q[kill_sid] <= 1'b0;
            if (set_en)     vld_q[set_sid]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_mem[set_sid] <= set_tag;
    end

endmodule

// File: rtl/ssp_scrub_fsm.sv
module ssp_scrub_fsm
    import ssp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_req,
    output logic             busy,
    output logic [IDX_W-1:0] wipe_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    scrub_state_e     state_q, state_d;
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCRUB_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == SCRUB_WALK) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCRUB_IDLE: if (clear_req)          state_d = SCRUB_WALK;
            SCRUB_WALK: if (cnt_q == LAST_IDX)  state_d = SCRUB_IDLE;
            default:                            state_d = SCRUB_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q == SCRUB_WALK);
        wipe_idx = cnt_q;
    end

endmodule

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10,
    parameter int SID_W = 7,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             fetch_is_store,
    input  logic [TAG_W-1:0] fetch_tag,
    input  logic             done_valid,
    input  logic [PC_W-1:0]  done_pc,
    input  logic [TAG_W-1:0] done_tag,
    input  logic             viol_valid,
    input  logic [PC_W-1:0]  viol_load_pc,
    input  logic [PC_W-1:0]  viol_store_pc,
    input  logic             clear_req,
    output logic             pred_valid,
    output logic             pred_dep,
    output logic [TAG_W-1:0] pred_tag
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic             scrub_busy;
    logic [IDX_W-1:0] wipe_idx;
    logic             f_hit, d_hit;
    logic [SID_W-1:0] f_sid, d_sid;
    logic             rec_vld;
    logic [TAG_W-1:0] rec_tag;
    logic             f_member;
    logic             unused_pc_bits;

    assign unused_pc_bits = ^{fetch_pc[PC_W-1:IDX_HI+1], fetch_pc[IDX_LO-1:0],
                              done_pc[PC_W-1:IDX_HI+1], done_pc[IDX_LO-1:0],
                              viol_load_pc[PC_W-1:IDX_HI+1], viol_load_pc[IDX_LO-1:0],
                              viol_store_pc[PC_W-1:IDX_HI+1], viol_store_pc[IDX_LO-1:0]};

    ssp_scrub_fsm #(.IDX_W(IDX_W)) u_scrub (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_req (clear_req),
        .busy      (scrub_busy),
        .wipe_idx  (wipe_idx)
    );

    ssp_sid_table #(.IDX_W(IDX_W), .SID_W(SID_W)) u_sid (
        .clk          (clk),
        .rst_n        (rst_n),
        .look_a_idx   (fetch_pc[IDX_HI:IDX_LO]),
        .look_a_hit   (f_hit),
        .look_a_sid   (f_sid),
        .look_b_idx   (done_pc[IDX_HI:IDX_LO]),
        .look_b_hit   (d_hit),
        .look_b_sid   (d_sid),
        .train_en     (viol_valid && !scrub_busy),
        .train_ld_idx (viol_load_pc[IDX_HI:IDX_LO]),
        .train_st_idx (viol_store_pc[IDX_HI:IDX_LO]),
        .wipe_en      (scrub_busy),
        .wipe_idx     (wipe_idx)
    );

    assign f_member = f_hit && !scrub_busy;

    ssp_lfst #(.SID_W(SID_W), .TAG_W(TAG_W)) u_lfst (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sid   (f_sid),
        .rd_vld   (rec_vld),
        .rd_tag   (rec_tag),
        .set_en   (fetch_valid && fetch_is_store && f_member),
        .set_sid  (f_sid),
        .set_tag  (fetch_tag),
        .kill_en  (done_valid && d_hit),
        .kill_sid (d_sid),
        .kill_tag (done_tag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_dep   <= 1'b0;
            pred_tag   <= '0;
        end else begin
            pred_valid <= fetch_valid;
            pred_dep   <= fetch_valid && f_member && rec_vld;
            pred_tag   <= (fetch_valid && f_member && rec_vld) ? rec_tag : '0;
        end
    end

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int IDX_W = 10
) (
    input logic clk,
    input logic rst_n,
    input logic fetch_valid,
    input logic clear_req,
    input logic scrub_busy,
    input logic pred_valid,
    input logic pred_dep
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W:0] walk_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          walk_cnt <= '0;
        else if (scrub_busy) walk_cnt <= walk_cnt + 1'b1;
        else                 walk_cnt <= '0;
    end

    a_r2_answer_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> pred_valid);

    a_r2_no_answer_without_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !pred_valid);

    a_r3_dep_only_with_answer: assert property (@(posedge clk) disable iff (!rst_n)
        pred_dep |-> pred_valid);

    a_r10_walk_silences_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_busy && fetch_valid) |=> !pred_dep);

    a_r10_clear_starts_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !scrub_busy) |=> scrub_busy);

    a_r10_walk_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scrub_busy) |-> (walk_cnt == DEPTH[IDX_W:0]));

endmodule

bind store_set_predictor ssp_checker #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .clear_req   (clear_req),
    .scrub_busy  (scrub_busy),
    .pred_valid  (pred_valid),
    .pred_dep    (pred_dep)
);

// File: tb/sim_store_set_predictor.sv
module sim_store_set_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_is_store = 1'b0;
    logic [5:0]  fetch_tag = '0;
    logic        done_valid = 1'b0;
    logic [31:0] done_pc = '0;
    logic [5:0]  done_tag = '0;
    logic        viol_valid = 1'b0;
    logic [31:0] viol_load_pc = '0;
    logic [31:0] viol_store_pc = '0;
    logic        clear_req = 1'b0;
    logic        pred_valid, pred_dep;
    logic [5:0]  pred_tag;

    int vectors = 0;
    int errors  = 0;
    bit ended   = 0;

    always #10 clk = ~clk;

    store_set_predictor u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_is_store(fetch_is_store), .fetch_tag(fetch_tag),
        .done_valid(done_valid), .done_pc(done_pc), .done_tag(done_tag),
        .viol_valid(viol_valid), .viol_load_pc(viol_load_pc),
        .viol_store_pc(viol_store_pc), .clear_req(clear_req),
        .pred_valid(pred_valid), .pred_dep(pred_dep), .pred_tag(pred_tag)
    );

    task automatic expect_pred(input string req, input logic dep, input logic [5:0] tag);
        logic [5:0] t;
        t = dep ? tag : 6'd0;
        vectors++;
        if (pred_valid !== 1'b1 || pred_dep !== dep || pred_tag !== t) begin
            errors++;
            $display("FAIL %s: valid=%b dep=%b tag=%0d expected valid=1 dep=%b tag=%0d",
                     req, pred_valid, pred_dep, pred_tag, dep, t);
        end
    endtask

    task automatic fetch(input logic [31:0] pc, input logic st, input logic [5:0] tag);
        fetch_valid = 1'b1; fetch_pc = pc; fetch_is_store = st; fetch_tag = tag;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic violate(input logic [31:0] lpc, input logic [31:0] spc);
        viol_valid = 1'b1; viol_load_pc = lpc; viol_store_pc = spc;
        @(negedge clk);
        viol_valid = 1'b0;
    endtask

    task automatic complete(input logic [31:0] pc, input logic [5:0] tag);
        done_valid = 1'b1; done_pc = pc; done_tag = tag;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (pred_valid !== 1'b0 || pred_dep !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%b dep=%b expected 0 0", pred_valid, pred_dep);
        end
        rst_n = 1'b1;
        @(negedge clk);
        fetch(32'h100, 1'b0, 6'd1); expect_pred("R1", 1'b0, 6'd0);
        // R2: idle cycle has no answer
        @(negedge clk);
        vectors++;
        if (pred_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: valid=%b expected 0", pred_valid);
        end
        // R3: unknown store
        fetch(32'h004, 1'b1, 6'd2); expect_pred("R3", 1'b0, 6'd0);

        // R11: violation and fetch in the same cycle; the fetch sees the old table
        viol_valid = 1'b1; viol_load_pc = 32'h100; viol_store_pc = 32'h004;
        fetch(32'h100, 1'b0, 6'd3);
        viol_valid = 1'b0;
        expect_pred("R11", 1'b0, 6'd0);

        // R4/R5/R6
        fetch(32'h004, 1'b1, 6'd5); expect_pred("R6", 1'b0, 6'd0);
        fetch(32'h100, 1'b0, 6'd6); expect_pred("R4", 1'b1, 6'd5);
        fetch(32'h100, 1'b0, 6'd6); expect_pred("R5", 1'b1, 6'd5);
        fetch(32'h004, 1'b1, 6'd9); expect_pred("R6", 1'b1, 6'd5);
        fetch(32'h100, 1'b0, 6'd6); expect_pred("R6", 1'b1, 6'd9);
        // R7: stale tag leaves the record
        complete(32'h004, 6'd5);
        fetch(32'h100, 1'b0, 6'd6); expect_pred("R7", 1'b1, 6'd9);
        // R11: completion and fetch in the same cycle
        done_valid = 1'b1; done_pc = 32'h004; done_tag = 6'd9;
        fetch(32'h100, 1'b0, 6'd6);
        done_valid = 1'b0;
        expect_pred("R11", 1'b1, 6'd9);
        fetch(32'h100, 1'b0, 6'd6); expect_pred("R7", 1'b0, 6'd0);

        // R9: 0x100 in set 0x40, 0x080 trained into set 0x20, then merged
        violate(32'h080, 32'h008);
        violate(32'h100, 32'h008);
        fetch(32'h008, 1'b1, 6'd3); expect_pred("R9", 1'b0, 6'd0);
        fetch(32'h080, 1'b0, 6'd1); expect_pred("R9", 1'b1, 6'd3);
        fetch(32'h100, 1'b0, 6'd1); expect_pred("R9", 1'b1, 6'd3);

        // R8: load 0x200 joins the store's set 0x40
        violate(32'h200, 32'h004);
        fetch(32'h004, 1'b1, 6'd7); expect_pred("R8", 1'b0, 6'd0);
        fetch(32'h200, 1'b0, 6'd1); expect_pred("R8", 1'b1, 6'd7);

        // R10: wipe
        clear_req = 1'b1; @(negedge clk); clear_req = 1'b0;
        fetch(32'h200, 1'b0, 6'd1); expect_pred("R10", 1'b0, 6'd0);
        violate(32'h280, 32'h00C);
        repeat (1100) @(negedge clk);
        fetch(32'h00C, 1'b1, 6'd2); expect_pred("R10", 1'b0, 6'd0);
        fetch(32'h280, 1'b0, 6'd1); expect_pred("R10", 1'b0, 6'd0);
        fetch(32'h200, 1'b0, 6'd1); expect_pred("R10", 1'b0, 6'd0);
        violate(32'h100, 32'h010);
        fetch(32'h100, 1'b0, 6'd1); expect_pred("R10", 1'b1, 6'd7);

        // sweep: fresh sets number k, each trained, fetched and retired
        for (int k = 0; k < 32; k++) begin
            violate(32'h800 + 32'(k) * 4, 32'h400 + 32'(k) * 4);
            fetch(32'h400 + 32'(k) * 4, 1'b1, 6'(k)); expect_pred("R4", 1'b0, 6'd0);
            fetch(32'h800 + 32'(k) * 4, 1'b0, 6'd63); expect_pred("R5", 1'b1, 6'(k));
            complete(32'h400 + 32'(k) * 4, 6'(k));
            fetch(32'h800 + 32'(k) * 4, 1'b0, 6'd63); expect_pred("R7", 1'b0, 6'd0);
        end

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule